// File: doc/BRIEF.md
# Programmable Periodic Down-Counter Timer

This block is a 32-bit timer that counts down by one on each prescaled tick and sits behind a small word-addressed register bus. Software chooses one of three clock-enable inputs as the tick source, or none. A 12-bit prescaler divides that source. The counter either reloads from a programmable load value or wraps through the full 32-bit range. When the count reaches a programmed compare value, a sticky status flag is set. That flag drives a level interrupt while the compare interrupt and the timer are both enabled.

Counting is run by a two-state machine. **HALT** is entered at reset and on a control write that clears the enable bit. In HALT the count holds its value and no tick is produced. **COUNT** is entered on a control write that sets the enable bit while it was clear; this is the *start* transition. If the enable-mode bit is set in that same write, the count is restarted at that point. The transition from COUNT back to HALT is the *stop* transition. A software-reset write leaves the machine in whichever state the enable bit it writes selects.

Top module: `dct_timer`

## Requirements
- R1: Register word addresses are 0 control, 1 status, 2 load, 3 compare and 4 count (read only). A read at any other address returns 0, and a write there changes no register.
- R2: Control bits [25:24] choose the tick source: 00 none, 01 `ce_periph`, 10 `ce_fast`, 11 `ce_slow`. A pulse on an unselected input has no effect on the count.
- R3: The prescale field (control bits [15:4], value P) lets one tick through for every P+1 selected enable pulses while running. The prescaler restarts from zero whenever the timer is halted.
- R4: A control write stores only bits [25:0], and bits [31:26] read as 0. The software-reset bit (16) is never stored and always reads 0. Other control bits are: 0 enable, 1 enable-mode, 2 compare interrupt enable, 3 reload mode, 17 immediate overwrite, 18 to 21 low-power mode bits (stored only).
- R5: A control write with bit 16 set keeps only bits 0, 1 and 18 to 21 of the written value and clears all other control bits. It also clears status, compare and count, and sets load to 0xFFFFFFFF, all in the same cycle.
- R6: A control write that sets enable while it was clear, with enable-mode set and no software reset, loads the count with the load value when the written reload-mode bit (3) is set, and with 0xFFFFFFFF when it is clear.
- R7: A tick at count 0 loads the load value in reload mode and 0xFFFFFFFF otherwise. Any other tick decrements the count by one.
- R8: A load write updates the load value. If immediate overwrite is set, the count takes the written value in the same cycle, whatever the reload mode. Otherwise the count is left unchanged.
- R9: Status bit 0 is set when a tick brings the count to the compare value. Writing 1 to status bit 0 clears it, and writing 0 leaves it set. If a clear and a match happen in the same cycle, the flag stays set.
- R10: `irq` is high exactly while status bit 0, the compare interrupt enable bit and the enable bit are all 1.
- R11: While halted, the count holds its value, still reads back, and ignores enable pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| ce_periph | input | 1 | Clock-enable pulse of tick source 01 |
| ce_fast | input | 1 | Clock-enable pulse of tick source 10 |
| ce_slow | input | 1 | Clock-enable pulse of tick source 11 |
| irq | output | 1 | Level compare interrupt |

## Verification
Read data is combinational, so a register's new value can be read right after the clock edge that captures its write. Count, status and `irq` change at the same edge that captures the write or the enable pulse that caused the change. The bench presents every stimulus for exactly one edge, one time unit after a rising edge. It puts each expected value into a queue at the address phase and compares it at the next falling edge, before any further edge can move the state. Enable pulses are only issued deliberately, so each expected count follows from the pulses sent since the last check.

// File: rtl/dct_pkg.sv
package dct_pkg;
    // prescale field width; control layout is derived from it
    localparam int PRESC_W  = 12;

    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_OCIE   = 2;
    localparam int B_RLD    = 3;
    localparam int B_PS_LO  = 4;
    localparam int B_SWR    = B_PS_LO + PRESC_W;
    localparam int B_IOVW   = B_SWR + 1;
    localparam int B_LP_LO  = B_IOVW + 1;       // four stored low-power bits
    localparam int LP_W     = 4;
    localparam int B_CS_LO  = B_SWR + 8;
    localparam int CTRL_W   = B_CS_LO + 2;

    localparam int A_CTRL   = 0;
    localparam int A_STAT   = 1;
    localparam int A_LOAD   = 2;
    localparam int A_CMP    = 3;
    localparam int A_COUNT  = 4;

    typedef enum logic [1:0] {
        CS_OFF    = 2'b00,
        CS_PERIPH = 2'b01,
        CS_FAST   = 2'b10,
        CS_SLOW   = 2'b11
    } clksrc_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_e;

    function automatic logic [CTRL_W-1:0] swr_keep_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[B_EN]    = 1'b1;
        m[B_ENMOD] = 1'b1;
        for (int i = 0; i < LP_W; i++) begin
            m[B_LP_LO + i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dct_tick.sv
module dct_tick
    import dct_pkg::*;
#(
    parameter int PSW = PRESC_W,
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ce_i,
    input  clksrc_e         src_i,
    input  logic [PSW-1:0]  presc_i,
    input  logic            run_i,
    output logic            tick_o
);
    logic           sel_ce;
    logic [PSW-1:0] pre_q;
    logic [NSRC:0]  ce_ext;

    // slot 0 is the "off" source; slots 1..NSRC map to the inputs
    assign ce_ext[0] = 1'b0;
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign ce_ext[g+1] = ce_i[g];
    end

    always_comb begin
        unique case (src_i)
            CS_OFF:    sel_ce = ce_ext[0];
            CS_PERIPH: sel_ce = ce_ext[1];
            CS_FAST:   sel_ce = ce_ext[2];
            CS_SLOW:   sel_ce = ce_ext[3];
            default:   sel_ce = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i) begin
            pre_q <= '0;
        end else if (sel_ce) begin
            if (pre_q >= presc_i) pre_q <= '0;
            else                  pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = run_i && sel_ce && (pre_q >= presc_i);

    AST_PRESC_CLEAR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> pre_q == '0);                                    // R3
endmodule

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          restart_i,
    input  logic [DW-1:0] restart_val_i,
    input  logic          rld_mode_i,
    input  logic          swr_i,
    input  logic          ovw_i,
    input  logic [DW-1:0] ovw_val_i,
    input  logic [DW-1:0] load_i,
    input  logic [DW-1:0] cmp_i,
    output logic [DW-1:0] cnt_o,
    output logic          cmp_hit_o,
    output logic          run_o
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    run_st_e       state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d, cnt_step;
    logic          step_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: HALT --start--> COUNT, COUNT --stop--> HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (start_i) state_d = ST_COUNT;
            ST_COUNT: if (stop_i)  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ST_HALT:  run_o = 1'b0;
            ST_COUNT: run_o = 1'b1;
            default:  run_o = 1'b0;
        endcase
    end

    assign step_en  = run_o && tick_i;
    assign cnt_step = (cnt_q == '0) ? (rld_mode_i ? load_i : ALL_ONES)
                                    : cnt_q - 1'b1;

    always_comb begin
        if (swr_i)          cnt_d = '0;
        else if (ovw_i)     cnt_d = ovw_val_i;
        else if (restart_i) cnt_d = restart_val_i;
        else if (step_en)   cnt_d = cnt_step;
        else                cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cmp_hit_o = step_en && !swr_i && !ovw_i && (cnt_step == cmp_i);
    assign cnt_o     = cnt_q;

    AST_HOLD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !swr_i && !ovw_i && !restart_i)
        |=> cnt_q == $past(cnt_q));                                 // R11
    AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick_i && cnt_q == '0 && !swr_i && !ovw_i)
        |=> cnt_q == ($past(rld_mode_i) ? $past(load_i) : ALL_ONES)); // R7
    AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovw_i && !swr_i) |=> cnt_q == $past(ovw_val_i));           // R8
    AST_HIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit_o |=> cnt_q == $past(cmp_i));                       // R9
endmodule

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     cnt_i,
    input  logic              cmp_hit_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DW-1:0]     load_o,
    output logic [DW-1:0]     cmp_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              restart_o,
    output logic [DW-1:0]     restart_val_o,
    output logic              swr_o,
    output logic              ovw_o,
    output logic              irq_o
);
    localparam logic [CTRL_W-1:0] KEEP = swr_keep_mask();

    logic [CTRL_W-1:0] ctrl_q, wctrl;
    logic              sr_q;
    logic [DW-1:0]     load_q, cmp_q;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;

    assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
    assign wr_stat = bus_wr && (bus_addr == AW'(A_STAT));
    assign wr_load = bus_wr && (bus_addr == AW'(A_LOAD));
    assign wr_cmp  = bus_wr && (bus_addr == AW'(A_CMP));
    assign wctrl   = bus_wdata[CTRL_W-1:0];

    assign swr_o     = wr_ctrl && wctrl[B_SWR];
    assign start_o   = wr_ctrl && wctrl[B_EN] && !ctrl_q[B_EN];
    assign stop_o    = wr_ctrl && !wctrl[B_EN] && ctrl_q[B_EN];
    assign restart_o = start_o && wctrl[B_ENMOD] && !wctrl[B_SWR];
    assign restart_val_o = wctrl[B_RLD] ? load_q : {DW{1'b1}};
    assign ovw_o     = wr_load && ctrl_q[B_IOVW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sr_q   <= 1'b0;
            load_q <= {DW{1'b1}};
            cmp_q  <= '0;
        end else begin
            if (swr_o) begin
                ctrl_q <= wctrl & KEEP;
                load_q <= {DW{1'b1}};
                cmp_q  <= '0;
            end else begin
                if (wr_ctrl) begin
                    ctrl_q         <= wctrl;
                    ctrl_q[B_SWR]  <= 1'b0;
                end
                if (wr_load) load_q <= bus_wdata;
                if (wr_cmp)  cmp_q  <= bus_wdata;
            end
            if (swr_o)                        sr_q <= 1'b0;
            else if (cmp_hit_i)               sr_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) sr_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_CTRL):  bus_rdata[CTRL_W-1:0] = ctrl_q;
            AW'(A_STAT):  bus_rdata[0]          = sr_q;
            AW'(A_LOAD):  bus_rdata             = load_q;
            AW'(A_CMP):   bus_rdata             = cmp_q;
            AW'(A_COUNT): bus_rdata             = cnt_i;
            default:      bus_rdata             = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign cmp_o  = cmp_q;
    assign irq_o  = sr_q && ctrl_q[B_OCIE] && ctrl_q[B_EN];

    AST_SWR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        swr_o |=> (load_q == {DW{1'b1}} && cmp_q == '0 && !sr_q));   // R5
    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit_i && !swr_o) |=> sr_q);                            // R9
    AST_SWR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !ctrl_q[B_SWR]);                                // R4
    AST_FLAG_KEEP_ZERO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q && wr_stat && !bus_wdata[0]) |=> sr_q);               // R9
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ce_periph,
    input  logic          ce_fast,
    input  logic          ce_slow,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl;
    logic [DW-1:0]     load, cmp, cnt, restart_val;
    logic              start, stop, restart, swr, ovw, cmp_hit, run, tick;

    dct_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_i(cnt), .cmp_hit_i(cmp_hit),
        .ctrl_o(ctrl), .load_o(load), .cmp_o(cmp),
        .start_o(start), .stop_o(stop), .restart_o(restart),
        .restart_val_o(restart_val), .swr_o(swr), .ovw_o(ovw),
        .irq_o(irq)
    );

    dct_tick #(.PSW(PRESC_W), .NSRC(3)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .ce_i({ce_slow, ce_fast, ce_periph}),
        .src_i(clksrc_e'(ctrl[B_CS_LO +: 2])),
        .presc_i(ctrl[B_PS_LO +: PRESC_W]),
        .run_i(run),
        .tick_o(tick)
    );

    dct_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick), .start_i(start), .stop_i(stop),
        .restart_i(restart), .restart_val_i(restart_val),
        .rld_mode_i(ctrl[B_RLD]), .swr_i(swr),
        .ovw_i(ovw), .ovw_val_i(bus_wdata),
        .load_i(load), .cmp_i(cmp),
        .cnt_o(cnt), .cmp_hit_o(cmp_hit), .run_o(run)
    );

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> run);                                               // R10
endmodule

// File: tb/tb_dct_timer.sv
module tb_dct_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ce_periph = 1'b0, ce_fast = 1'b0, ce_slow = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    dct_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ce_periph(ce_periph), .ce_fast(ce_fast), .ce_slow(ce_slow),
        .irq(irq)
    );

    // monitor: pops expected items and compares away from the rising edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = it.is_irq ? {31'b0, irq} : bus_rdata;
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s got=%h exp=%h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = t;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    // which: 0 periph, 1 fast, 2 slow
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ce_periph = (which == 0); ce_fast = (which == 1); ce_slow = (which == 2);
            @(posedge clk); #1;
            ce_periph = 1'b0; ce_fast = 1'b0; ce_slow = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        chk(0, 32'h0, "R4 reset ctrl");
        chk(1, 32'h0, "R9 reset status");
        chk(2, 32'hFFFF_FFFF, "R5 reset load");
        chk(4, 32'h0, "R11 reset count");
        chk_irq(1'b0, "R10 reset irq");

        // reload mode start from load value, source periph
        wr(2, 32'd10);
        wr(3, 32'd7);
        wr(0, 32'h0100_000F);
        chk(4, 32'd10, "R6 start from load");
        chk(0, 32'h0100_000F, "R4 ctrl readback");
        pulse(0, 3);
        chk(4, 32'd7, "R7 decrement");
        chk(1, 32'd1, "R9 flag on match");
        chk_irq(1'b1, "R10 irq asserted");

        // interrupt gating by compare-interrupt enable
        wr(0, 32'h0100_000B);
        chk_irq(1'b0, "R10 irq gated");
        chk(1, 32'd1, "R9 flag kept");
        wr(0, 32'h0100_000F);
        chk_irq(1'b1, "R10 irq regated");

        // status write semantics
        wr(1, 32'h0);
        chk(1, 32'd1, "R9 write zero no effect");
        wr(1, 32'h1);
        chk(1, 32'd0, "R9 write one clears");
        chk_irq(1'b0, "R10 irq drops");

        // reach zero and reload
        pulse(0, 7);
        chk(4, 32'd0, "R7 reached zero");
        pulse(0, 1);
        chk(4, 32'd10, "R7 reload from load");
        chk(1, 32'd0, "R9 no spurious flag");

        // unselected sources ignored
        pulse(1, 2);
        pulse(2, 2);
        chk(4, 32'd10, "R2 unselected ignored");

        // prescale 2 -> one tick per three pulses
        wr(0, 32'h0100_002F);
        pulse(0, 3);
        chk(4, 32'd9, "R3 prescaled tick");
        pulse(0, 2);
        chk(4, 32'd9, "R3 no tick before third");
        pulse(0, 1);
        chk(4, 32'd8, "R3 tick on third");

        // disable holds count
        wr(0, 32'h0100_002E);
        pulse(0, 5);
        chk(4, 32'd8, "R11 hold while halted");

        // free-running start from all ones on slow source
        wr(0, 32'h0300_0003);
        chk(4, 32'hFFFF_FFFF, "R6 start from all ones");
        pulse(2, 1);
        chk(4, 32'hFFFF_FFFE, "R2 slow source ticks");

        // immediate overwrite without reload mode, then wrap
        wr(0, 32'h0302_0003);
        wr(2, 32'd1);
        chk(4, 32'd1, "R8 overwrite no reload mode");
        pulse(2, 2);
        chk(4, 32'hFFFF_FFFF, "R7 wrap to all ones");

        // reload mode without overwrite leaves count alone
        wr(0, 32'h0300_000B);
        wr(2, 32'd5);
        chk(4, 32'hFFFF_FFFF, "R8 no overwrite");
        chk(2, 32'd5, "R8 load updated");

        // reload mode with overwrite, then reload cycle
        wr(0, 32'h0302_000B);
        wr(2, 32'd3);
        chk(4, 32'd3, "R8 overwrite reload mode");
        pulse(2, 4);
        chk(4, 32'd3, "R7 reload after zero");

        // upper control bits dropped
        wr(0, 32'hFF02_000B);
        chk(0, 32'h0302_000B, "R4 upper bits zero");

        // unmapped addresses
        wr(5, 32'h1234_5678);
        chk(5, 32'h0, "R1 unmapped read 5");
        chk(7, 32'h0, "R1 unmapped read 7");
        chk(3, 32'd7, "R1 compare untouched");
        chk(2, 32'd3, "R1 load untouched");

        // set flag, then software reset
        wr(3, 32'd2);
        wr(0, 32'h0302_000F);
        pulse(2, 1);
        chk(1, 32'd1, "R9 flag before swr");
        wr(0, 32'h033F_00FF);
        chk(0, 32'h003C_0003, "R5 swr keeps bits");
        chk(1, 32'd0, "R5 swr clears status");
        chk(3, 32'd0, "R5 swr clears compare");
        chk(2, 32'hFFFF_FFFF, "R5 swr sets load");
        chk(4, 32'd0, "R5 swr clears count");
        pulse(0, 1);
        pulse(1, 1);
        pulse(2, 1);
        chk(4, 32'd0, "R2 source off no ticks");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule